// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block holds 64 software-loaded address translations for 8 KB data pages. A load/store unit presents a 32-bit virtual address with a translation enable. The block then reports, in the same cycle, whether the indexed entry matches. It also gives the 19-bit physical page number and the four access-permission flags (read and write, for user and for supervisor) stored for that entry. Exception generation and assembly of the full physical address are left to the surrounding logic. The low 13 address bits never enter the block's decision.

Storage is direct-mapped. Virtual address bits 18:13 pick the single candidate entry, and bits 31:19 are compared against the tag stored there. Software fills and inspects entries through a special-purpose-register port. Each entry appears as two 32-bit words on that port: a match word, holding the tag and a valid flag, and a translate word, holding the page number and the permission flags. Reset invalidates every entry.

Top module: `dtlb_dm`

## Requirements
- R1: With `xlat_en` high, `hit` is 1 exactly when the entry indexed by `vaddr[18:13]` is valid and its stored tag equals `vaddr[31:19]`. `vaddr[12:0]` has no effect.
- R2: With `xlat_en` high, `ppn` shows the page number stored in the entry indexed by `vaddr[18:13]`, whether or not that lookup hits.
- R3: With `xlat_en` high, `perm_uw`, `perm_ur`, `perm_sw` and `perm_sr` show that indexed entry's stored flags, taken from translate-word bits 9, 8, 7 and 6 in that order.
- R4: With `xlat_en` low, `hit`, `ppn` and all four permission outputs are 0.
- R5: A port access reaches the block only when `spr_sel` is 1 and `spr_addr[10]` is 1. `spr_addr[9]` = 0 selects the match word and 1 selects the translate word. `spr_addr[5:0]` selects the entry. All other address bits are ignored, so 0x0C00+n and 0x0E00+n address entry n.
- R6: A match-word write stores `spr_wdata[31:19]` as the tag and `spr_wdata[0]` as the valid flag. Its other data bits are discarded.
- R7: A translate-word write stores `spr_wdata[31:13]` as the page number and `spr_wdata[9:6]` as the flags {uw, ur, sw, sr}. Its other data bits are discarded.
- R8: A match-word read returns the tag in bits 31:19 and the valid flag in bit 0. A translate-word read returns the page number in bits 31:13 and the flags in bits 9:6. All other bits read as 0, and `spr_rdata` is 0 whenever no access reaches the block.
- R9: Reset (`rst` high, asynchronous) clears every valid flag, so no lookup hits until an entry is written valid.
- R10: Lookup and read-back are combinational. A write happens only when `spr_we` is high during a selected access, and it becomes visible after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| xlat_en | input | 1 | Translation enable |
| vaddr | input | 32 | Virtual address to look up |
| hit | output | 1 | Indexed entry is valid and its tag matches |
| ppn | output | 19 | Physical page number of the indexed entry |
| perm_uw | output | 1 | User write permitted |
| perm_ur | output | 1 | User read permitted |
| perm_sw | output | 1 | Supervisor write permitted |
| perm_sr | output | 1 | Supervisor read permitted |
| spr_sel | input | 1 | Register port chip select |
| spr_we | input | 1 | Register port write strobe |
| spr_addr | input | 16 | Register port address |
| spr_wdata | input | 32 | Register port write data |
| spr_rdata | output | 32 | Register port read data |

## Verification
The bench builds the block with its default parameters: 6 index bits, 13 offset bits and 32-bit addresses. At that size all 64 entries can be swept in full. Every entry is written with a distinct computed tag, page number, flag pattern and valid value, with noise placed in the discarded data bits. Each entry is then read back through both words and looked up once with its own tag and once with a mismatching tag. The sweep also covers the disabled-lookup case, writes that must be ignored, address aliasing, the edge at which a write takes effect, and a second reset.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Register-word layout seen through the special-purpose-register port.
  localparam int REG_W         = 32;
  localparam int VLD_POS       = 0;
  localparam int PERM_LO       = 6;   // sr=6, sw=7, ur=8, uw=9
  localparam int TLB_SEL_BIT   = 10;
  localparam int XLATE_SEL_BIT = 9;

  typedef struct packed {
    logic uw;
    logic ur;
    logic sw;
    logic sr;
  } perm_t;

  typedef enum logic [1:0] {
    SPR_NONE  = 2'd0,
    SPR_MATCH = 2'd1,
    SPR_XLATE = 2'd2
  } spr_kind_e;
endpackage

// File: rtl/xlat_spr_decode.sv
module xlat_spr_decode
  import xlat_pkg::*;
#(
  parameter int SPR_AW   = 16,
  parameter int IDX_BITS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                spr_sel,
  input  logic                spr_we,
  input  logic [SPR_AW-1:0]   spr_addr,
  output spr_kind_e           kind,
  output logic                wr_match,
  output logic                wr_xlate,
  output logic [IDX_BITS-1:0] idx
);
  logic tlb_sel;
  logic unused_addr_bits;

  assign tlb_sel = spr_sel & spr_addr[TLB_SEL_BIT];

  always_comb begin
    if (!tlb_sel)                    kind = SPR_NONE;
    else if (spr_addr[XLATE_SEL_BIT]) kind = SPR_XLATE;
    else                             kind = SPR_MATCH;
  end

  assign wr_match = spr_we && (kind == SPR_MATCH);
  assign wr_xlate = spr_we && (kind == SPR_XLATE);
  assign idx      = spr_addr[IDX_BITS-1:0];

  assign unused_addr_bits = ^spr_addr;

  // R5: nothing reaches storage without chip select and the TLB address bit
  a_r5_no_write_unselected : assert property (@(posedge clk) disable iff (rst)
    (!spr_sel || !spr_addr[TLB_SEL_BIT]) |-> (!wr_match && !wr_xlate));
  // R10: a write strobe is needed for any write
  a_r10_write_needs_strobe : assert property (@(posedge clk) disable iff (rst)
    !spr_we |-> (!wr_match && !wr_xlate));
endmodule

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
  import xlat_pkg::*;
#(
  parameter int IDX_BITS = 6,
  parameter int TAG_W    = 13,
  parameter int PPN_W    = 19,
  localparam int ENTRIES = 1 << IDX_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_match,
  input  logic                wr_xlate,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic                wr_vld,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  perm_t               wr_perm,
  input  logic [IDX_BITS-1:0] lk_idx,
  output logic                lk_vld,
  output logic [TAG_W-1:0]    lk_tag,
  output logic [PPN_W-1:0]    lk_ppn,
  output perm_t               lk_perm,
  output logic                rd_vld,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [PPN_W-1:0]    rd_ppn,
  output perm_t               rd_perm
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] match_sel;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic [PPN_W-1:0]   ppn_mem  [ENTRIES];
  perm_t              perm_mem [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
    assign match_sel[e] = wr_match && (wr_idx == IDX_BITS'(e));
  end

  // Valid flags are the only state that reset touches.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) vld_q <= '0;
    else     vld_q <= (vld_q & ~match_sel) | (match_sel & {ENTRIES{wr_vld}});
  end

  always_ff @(posedge clk) begin
    if (wr_match) tag_mem[wr_idx] <= wr_tag;
    if (wr_xlate) begin
      ppn_mem[wr_idx]  <= wr_ppn;
      perm_mem[wr_idx] <= wr_perm;
    end
  end

  assign lk_vld  = vld_q[lk_idx];
  assign lk_tag  = tag_mem[lk_idx];
  assign lk_ppn  = ppn_mem[lk_idx];
  assign lk_perm = perm_mem[lk_idx];
  assign rd_vld  = vld_q[wr_idx];
  assign rd_tag  = tag_mem[wr_idx];
  assign rd_ppn  = ppn_mem[wr_idx];
  assign rd_perm = perm_mem[wr_idx];

  // R6: a match write lands in the addressed valid flag on the next edge
  a_r6_valid_written : assert property (@(posedge clk) disable iff (rst)
    wr_match |=> (vld_q[$past(wr_idx)] == $past(wr_vld)));
  // R10: valid flags hold when no match write occurs
  a_r10_valid_held : assert property (@(posedge clk) disable iff (rst)
    !wr_match |=> $stable(vld_q));
endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
  import xlat_pkg::*;
#(
  parameter int TAG_W = 13,
  parameter int PPN_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xlat_en,
  input  logic [TAG_W-1:0] va_tag,
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [PPN_W-1:0] ent_ppn,
  input  perm_t            ent_perm,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  output perm_t            perm
);
  logic tag_eq;

  assign tag_eq = (va_tag == ent_tag);
  assign hit    = xlat_en & ent_vld & tag_eq;
  assign ppn    = xlat_en ? ent_ppn  : '0;
  assign perm   = xlat_en ? ent_perm : '0;

  // R1: a hit needs a valid indexed entry from storage
  a_r1_hit_needs_valid : assert property (@(posedge clk) disable iff (rst)
    hit |-> ent_vld);
  // R4: disabled lookups stay quiet
  a_r4_disabled_quiet : assert property (@(posedge clk) disable iff (rst)
    !xlat_en |-> (!hit && ppn == '0 && perm == '0));
endmodule

// File: rtl/dtlb_dm.sv
module dtlb_dm
  import xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 6,
  parameter int SPR_AW    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       xlat_en,
  input  logic [VA_W-1:0]            vaddr,
  output logic                       hit,
  output logic [VA_W-PAGE_BITS-1:0]  ppn,
  output logic                       perm_uw,
  output logic                       perm_ur,
  output logic                       perm_sw,
  output logic                       perm_sr,
  input  logic                       spr_sel,
  input  logic                       spr_we,
  input  logic [SPR_AW-1:0]          spr_addr,
  input  logic [REG_W-1:0]           spr_wdata,
  output logic [REG_W-1:0]           spr_rdata
);
  localparam int PPN_W = VA_W - PAGE_BITS;
  localparam int TAG_W = PPN_W - IDX_BITS;

  function automatic logic [IDX_BITS-1:0] f_vidx(input logic [VA_W-1:0] va);
    return va[PAGE_BITS +: IDX_BITS];
  endfunction

  function automatic logic [TAG_W-1:0] f_vtag(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: TAG_W];
  endfunction

  function automatic logic [REG_W-1:0] f_match_word(input logic [TAG_W-1:0] tag,
                                                    input logic vld);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1 -: TAG_W] = tag;
    w[VLD_POS] = vld;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] f_xlate_word(input logic [PPN_W-1:0] pn,
                                                    input perm_t pm);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1 -: PPN_W] = pn;
    w[PERM_LO +: 4] = pm;
    return w;
  endfunction

  spr_kind_e           kind;
  logic                wr_match, wr_xlate;
  logic [IDX_BITS-1:0] spr_idx;
  logic                lk_vld, rd_vld;
  logic [TAG_W-1:0]    lk_tag, rd_tag;
  logic [PPN_W-1:0]    lk_ppn, rd_ppn;
  perm_t               lk_perm, rd_perm, out_perm;
  logic                unused_bits;

  assign unused_bits = ^{vaddr[PAGE_BITS-1:0], spr_wdata};

  xlat_spr_decode #(.SPR_AW(SPR_AW), .IDX_BITS(IDX_BITS)) u_dec (
    .clk(clk), .rst(rst), .spr_sel(spr_sel), .spr_we(spr_we),
    .spr_addr(spr_addr), .kind(kind), .wr_match(wr_match),
    .wr_xlate(wr_xlate), .idx(spr_idx)
  );

  xlat_entry_store #(.IDX_BITS(IDX_BITS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst(rst), .wr_match(wr_match), .wr_xlate(wr_xlate),
    .wr_idx(spr_idx),
    .wr_tag(spr_wdata[REG_W-1 -: TAG_W]),
    .wr_vld(spr_wdata[VLD_POS]),
    .wr_ppn(spr_wdata[REG_W-1 -: PPN_W]),
    .wr_perm(perm_t'(spr_wdata[PERM_LO +: 4])),
    .lk_idx(f_vidx(vaddr)),
    .lk_vld(lk_vld), .lk_tag(lk_tag), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_ppn(rd_ppn), .rd_perm(rd_perm)
  );

  xlat_lookup #(.TAG_W(TAG_W), .PPN_W(PPN_W)) u_lk (
    .clk(clk), .rst(rst), .xlat_en(xlat_en), .va_tag(f_vtag(vaddr)),
    .ent_vld(lk_vld), .ent_tag(lk_tag), .ent_ppn(lk_ppn), .ent_perm(lk_perm),
    .hit(hit), .ppn(ppn), .perm(out_perm)
  );

  assign perm_uw = out_perm.uw;
  assign perm_ur = out_perm.ur;
  assign perm_sw = out_perm.sw;
  assign perm_sr = out_perm.sr;

  always_comb begin
    unique case (kind)
      SPR_MATCH: spr_rdata = f_match_word(rd_tag, rd_vld);
      SPR_XLATE: spr_rdata = f_xlate_word(rd_ppn, rd_perm);
      default:   spr_rdata = '0;
    endcase
  end

  // R8: reads outside the block's window return zero
  a_r8_unselected_zero : assert property (@(posedge clk) disable iff (rst)
    (!spr_sel || !spr_addr[TLB_SEL_BIT]) |-> (spr_rdata == '0));
  // R8: unimplemented match-word bits stay zero
  a_r8_match_pad_zero : assert property (@(posedge clk) disable iff (rst)
    (kind == SPR_MATCH) |-> (spr_rdata[REG_W-TAG_W-1:VLD_POS+1] == '0));
  // R2: an enabled lookup reports the stored page number
  a_r2_ppn_from_store : assert property (@(posedge clk) disable iff (rst)
    xlat_en |-> (ppn == lk_ppn));
endmodule

// File: tb/dtlb_dm_test.sv
module dtlb_dm_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        xlat_en;
  logic [31:0] vaddr;
  logic        hit;
  logic [18:0] ppn;
  logic        perm_uw, perm_ur, perm_sw, perm_sr;
  logic        spr_sel, spr_we;
  logic [15:0] spr_addr;
  logic [31:0] spr_wdata, spr_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtlb_dm uut (
    .clk(clk), .rst(rst), .xlat_en(xlat_en), .vaddr(vaddr), .hit(hit),
    .ppn(ppn), .perm_uw(perm_uw), .perm_ur(perm_ur), .perm_sw(perm_sw),
    .perm_sr(perm_sr), .spr_sel(spr_sel), .spr_we(spr_we),
    .spr_addr(spr_addr), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
  );

  function automatic logic [12:0] e_tag(input int i);
    return 13'((i * 331 + 17) & 32'h1FFF);
  endfunction
  function automatic logic [18:0] e_ppn(input int i);
    return 19'((i * 4099 + 1234) & 32'h7FFFF);
  endfunction
  function automatic logic [3:0] e_perm(input int i);
    return 4'((i ^ (i >> 2)) & 15);
  endfunction
  function automatic logic e_vld(input int i);
    return (i % 5) != 2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spr_wr(input logic sel, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    spr_sel = sel; spr_we = 1'b1; spr_addr = a; spr_wdata = d;
    @(negedge clk);
    spr_sel = 1'b0; spr_we = 1'b0;
  endtask

  task automatic spr_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    spr_sel = 1'b1; spr_we = 1'b0; spr_addr = a;
    #1 d = spr_rdata;
    spr_sel = 1'b0;
  endtask

  task automatic look(input logic en, input logic [31:0] va);
    @(negedge clk);
    xlat_en = en; vaddr = va;
    #1;
  endtask

  function automatic logic [31:0] va_of(input int i, input logic [12:0] tag);
    return {tag, 6'(i), 13'((i * 97) & 32'h1FFF)};
  endfunction

  task automatic check_entry(input string req, input int i, input logic [12:0] tag,
                             input logic exp_hit);
    look(1'b1, va_of(i, tag));
    chk($sformatf("%s hit entry %0d", req, i), 32'(hit), 32'(exp_hit));
    chk($sformatf("R2 ppn entry %0d", i), 32'(ppn), 32'(e_ppn(i)));
    chk($sformatf("R3 perms entry %0d", i), 32'({perm_uw, perm_ur, perm_sw, perm_sr}),
        32'(e_perm(i)));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; xlat_en = 1'b0; vaddr = '0;
    spr_sel = 1'b0; spr_we = 1'b0; spr_addr = '0; spr_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: after reset nothing is valid
    for (int i = 0; i < 64; i++) begin
      look(1'b1, va_of(i, e_tag(i)));
      chk($sformatf("R9 no hit after reset entry %0d", i), 32'(hit), 32'd0);
      spr_rd(16'h0C00 | 16'(i), d);
      chk($sformatf("R9 valid clear entry %0d", i), 32'(d[0]), 32'd0);
    end

    // R6 R7: fill every entry, with noise in the discarded data bits
    for (int i = 0; i < 64; i++) begin
      spr_wr(1'b1, 16'h0C00 | 16'(i), {e_tag(i), 18'h2A5A5, e_vld(i)});
      spr_wr(1'b1, 16'h0E00 | 16'(i), {e_ppn(i), 3'b101, e_perm(i), 6'h2D});
    end

    // R8: read back both words of each entry
    for (int i = 0; i < 64; i++) begin
      spr_rd(16'h0C00 | 16'(i), d);
      chk($sformatf("R8 R6 match word entry %0d", i), d, {e_tag(i), 18'h0, e_vld(i)});
      spr_rd(16'h0E00 | 16'(i), d);
      chk($sformatf("R8 R7 translate word entry %0d", i), d, {e_ppn(i), 3'b0, e_perm(i), 6'h0});
    end

    // R1 R2 R3: matching and mismatching tags
    for (int i = 0; i < 64; i++) begin
      check_entry("R1", i, e_tag(i), e_vld(i));
      check_entry("R1 miss", i, e_tag(i) ^ 13'h1000, 1'b0);
    end

    // R4: disabled lookups report nothing
    for (int i = 0; i < 64; i += 9) begin
      look(1'b0, va_of(i, e_tag(i)));
      chk($sformatf("R4 disabled entry %0d", i),
          {hit, perm_uw, perm_ur, perm_sw, perm_sr, ppn}, 32'd0);
    end

    // R5: writes without select or without address bit 10 are ignored
    spr_wr(1'b0, 16'h0C05, 32'hFFFF_FFFF);
    spr_wr(1'b1, 16'h0A05, 32'hFFFF_FFFF);
    spr_rd(16'h0C05, d);
    chk("R5 ignored match write", d, {e_tag(5), 18'h0, e_vld(5)});
    spr_rd(16'h0E05, d);
    chk("R5 ignored translate write", d, {e_ppn(5), 3'b0, e_perm(5), 6'h0});
    spr_rd(16'h0A05, d);
    chk("R8 read outside window", d, 32'd0);

    // R5: extra address bits alias to the same entry
    spr_wr(1'b1, 16'h1E47, {19'h5_1234, 3'b0, 4'b1001, 6'h0});
    look(1'b1, va_of(7, e_tag(7)));
    chk("R5 alias translate write ppn", 32'(ppn), 32'h5_1234);
    chk("R5 alias translate write perms", 32'({perm_uw, perm_ur, perm_sw, perm_sr}), 32'h9);

    // R10: a write is invisible before the edge and visible after it
    look(1'b1, va_of(3, e_tag(3)));
    @(negedge clk);
    spr_sel = 1'b1; spr_we = 1'b1; spr_addr = 16'h0C03; spr_wdata = {e_tag(3), 19'h0};
    #1 chk("R10 hit before write edge", 32'(hit), 32'(e_vld(3)));
    @(negedge clk);
    spr_sel = 1'b0; spr_we = 1'b0;
    #1 chk("R10 miss after write edge", 32'(hit), 32'd0);

    // R10: a read without strobe leaves the entry alone
    spr_rd(16'h0C04, d);
    look(1'b1, va_of(4, e_tag(4)));
    chk("R10 read has no effect", 32'(hit), 32'(e_vld(4)));

    // R9: a second reset invalidates previously valid entries
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 64; i += 7) begin
      look(1'b1, va_of(i, e_tag(i)));
      chk($sformatf("R9 second reset entry %0d", i), 32'(hit), 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule